// File: doc/BRIEF.md
# Message-Out Transmitter for a Parallel Initiator Bus

This block is the initiator's side of the message-out phase on a parallel, REQ/ACK handshaked bus. It keeps a small message buffer, which holds a length and up to three bytes. It fills that buffer from the fields of a command, or from a single byte handed over by other logic. It also drives the attention line that asks the target to enter message-out phase. Each time the target raises REQ in message-out phase, the block drives the next buffered byte onto the data lines and then acknowledges it.

Attention is released just before the final byte of a message is acknowledged. When the target asks for a message and the buffer is empty, the block sends a one-byte no-op. When the target asks for another byte after the buffer has been fully sent, the block treats this as a request for a retransmission: it raises attention again and restarts from the first byte. When the target moves to any other phase, the block drops attention, empties the buffer and pulses a done flag. It does not acknowledge that REQ, because the byte belongs to the next phase.

Phase encoding is {MSG, C/D, I/O} on `bus_phase[2:1:0]`. Message-out is 3'b110.

Top module: `msgout_tx`

## Requirements
- R1: After reset, `bus_ack`, `bus_atn`, `phase_done`, `busy_err` and `bus_data` are all 0, and the buffer is empty.
- R2: A `cmd_load` pulse with tagging off builds a one-byte identify message: 0x80 OR (0x40 when `cmd_disc` is 1) OR `cmd_lun` in bits 2:0. `bus_atn` reads 1 on the cycle after the pulse.
- R3: A `cmd_load` pulse with `cmd_tag_en` set builds three bytes, sent in ascending order: the identify byte, then 0x20 OR `cmd_tag_type` (0x20 is a simple queue tag), then `cmd_tag`.
- R4: If the target requests message-out while the buffer is empty, the block sends exactly one byte, 0x08 (no-op).
- R5: A REQ seen while `bus_perr` is 1 is ignored. No ACK is given and the message does not advance until the parity error clears.
- R6: A REQ whose phase is not 3'b110, seen while a message-out transfer is active, produces a one-cycle `phase_done` pulse with `bus_atn` low and no ACK. It also empties the buffer, so the next message-out entry sends a no-op.
- R7: `bus_atn` is already 0 when ACK rises for the last byte of a message, and is 1 when ACK rises for every earlier byte.
- R8: A message-out REQ that arrives after every buffered byte has been sent raises `bus_atn` again and resends the whole message from its first byte.
- R9: The data byte is driven one cycle before ACK rises. ACK rises two cycles after a REQ is seen in the middle of a message. ACK then stays high until REQ falls, and the data stays stable meanwhile.
- R10: A `one_req` pulse when the buffer is empty stores `one_byte` as a one-byte message and raises `bus_atn` on the next cycle.
- R11: A `one_req` pulse while the buffer holds a message pulses `busy_err` on the next cycle and leaves the buffered message unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Build a message from the command fields (accepted when no transfer is active) |
| cmd_lun | input | 3 | Logical unit number |
| cmd_disc | input | 1 | Disconnect privilege granted |
| cmd_tag_en | input | 1 | Command is tagged |
| cmd_tag_type | input | 2 | Queue tag type: 0 simple, 1 head of queue, 2 ordered |
| cmd_tag | input | 8 | Tag value |
| one_req | input | 1 | Request to send a single-byte message |
| one_byte | input | 8 | The single message byte |
| bus_req | input | 1 | Target REQ |
| bus_phase | input | 3 | {MSG, C/D, I/O} phase lines |
| bus_perr | input | 1 | Parity error flagged on the bus |
| bus_data | output | 8 | Outgoing message byte |
| bus_ack | output | 1 | Initiator ACK |
| bus_atn | output | 1 | Attention line |
| phase_done | output | 1 | One-cycle pulse when the target leaves message-out |
| busy_err | output | 1 | One-cycle pulse when a single-byte request finds the buffer in use |

## Verification
Some properties hold on every cycle and are checked by assertions. These cover the handshake shape: data stable when ACK rises, and ACK held while REQ stays high. They also cover the done pulse: it lasts one cycle, with attention low and no ACK.

Other behaviour depends on a whole sequence and only the bench's scenarios can show it. This covers the byte contents, including the identify and tag encodings. It covers attention falling exactly at the last byte, the resend after the buffer is exhausted, the no-op fill, the parity hold-off and the busy case. For these the bench compares each captured byte and its attention level against values it computes from the command fields.

// File: rtl/msgout_pkg.sv
package msgout_pkg;

    localparam int BYTE_W = 8;
    localparam int LUN_W  = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [2:0]        phase_t;

    // phase lines {MSG, C/D, I/O}
    localparam phase_t PH_MSG_OUT = 3'b110;

    localparam byte_t IDENT_FLAG = 8'h80;
    localparam byte_t DISC_PRIV  = 8'h40;
    localparam byte_t NOOP_MSG   = 8'h08;
    localparam byte_t TAG_ENABLE = 8'h20;

    typedef struct packed {
        logic [LUN_W-1:0] lun;
        logic             disc;
        logic             tag_en;
        logic [1:0]       tag_type;
        byte_t            tag;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_DRIVE,
        ST_ACK
    } seq_st_e;

    function automatic byte_t make_identify(input cmd_t c);
        byte_t b;
        b = IDENT_FLAG | byte_t'(c.lun);
        if (c.disc) b = b | DISC_PRIV;
        return b;
    endfunction

    function automatic byte_t make_tag_code(input cmd_t c);
        return TAG_ENABLE | byte_t'(c.tag_type);
    endfunction

endpackage

// File: rtl/msgout_build.sv
module msgout_build
    import msgout_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  cmd_t                          cmd_i,
    output logic [DEPTH-1:0][BYTE_W-1:0]  img_o,
    output logic [LEN_W-1:0]              img_len_o
);

    always_comb begin
        img_len_o = cmd_i.tag_en ? LEN_W'(3) : LEN_W'(1);
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_img
        if (k == 0) begin : g_ident
            assign img_o[k] = make_identify(cmd_i);
        end else if (k == 1) begin : g_code
            assign img_o[k] = cmd_i.tag_en ? make_tag_code(cmd_i) : '0;
        end else if (k == 2) begin : g_tag
            assign img_o[k] = cmd_i.tag_en ? cmd_i.tag : '0;
        end else begin : g_pad
            assign img_o[k] = '0;
        end
    end

endmodule

// File: rtl/msgout_buf.sv
module msgout_buf
    import msgout_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clear_i,
    input  logic                          nop_fill_i,
    input  logic                          load_cmd_i,
    input  logic [DEPTH-1:0][BYTE_W-1:0]  img_i,
    input  logic [LEN_W-1:0]              img_len_i,
    input  logic                          one_req_i,
    input  logic                          one_ok_i,
    input  byte_t                         one_byte_i,
    output logic [DEPTH-1:0][BYTE_W-1:0]  bytes_o,
    output logic [LEN_W-1:0]              len_o,
    output logic                          busy_err_o
);

    logic [DEPTH-1:0][BYTE_W-1:0] bytes_q;
    logic [LEN_W-1:0]             len_q;
    logic                         busy_q;
    logic                         one_take;

    assign one_take = one_req_i && one_ok_i && (len_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= '0;
            len_q   <= '0;
            busy_q  <= 1'b0;
        end else begin
            busy_q <= one_req_i && (len_q != '0);
            if (clear_i) begin
                len_q <= '0;
            end else if (nop_fill_i) begin
                bytes_q[0] <= NOOP_MSG;
                len_q      <= LEN_W'(1);
            end else if (load_cmd_i) begin
                bytes_q <= img_i;
                len_q   <= img_len_i;
            end else if (one_take) begin
                bytes_q[0] <= one_byte_i;
                len_q      <= LEN_W'(1);
            end
        end
    end

    assign bytes_o    = bytes_q;
    assign len_o      = len_q;
    assign busy_err_o = busy_q;

endmodule

// File: rtl/msgout_seq.sv
module msgout_seq
    import msgout_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_i,
    input  phase_t                        phase_i,
    input  logic                          perr_i,
    input  logic [DEPTH-1:0][BYTE_W-1:0]  bytes_i,
    input  logic [LEN_W-1:0]              len_i,
    input  logic                          atn_set_i,
    output logic                          idle_ok_o,
    output logic                          clear_o,
    output logic                          nop_fill_o,
    output byte_t                         data_o,
    output logic                          ack_o,
    output logic                          atn_o,
    output logic                          done_o
);

    seq_st_e           st_q;
    logic [LEN_W-1:0]  remain_q;
    logic [IDX_W-1:0]  idx_q;
    byte_t             data_q;
    logic              atn_q;
    logic              done_q;

    logic req_ok;
    logic in_msgout;
    logic start;

    assign req_ok    = req_i && !perr_i;
    assign in_msgout = (phase_i == PH_MSG_OUT);
    assign start     = (st_q == ST_IDLE) && req_ok && in_msgout;

    assign idle_ok_o  = (st_q == ST_IDLE) && !start;
    assign nop_fill_o = start && (len_i == '0);
    assign clear_o    = (st_q == ST_ACTIVE) && req_ok && !in_msgout;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            remain_q <= '0;
            idx_q    <= '0;
            data_q   <= '0;
            atn_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (atn_set_i) atn_q <= 1'b1;
                    if (start) begin
                        idx_q <= '0;
                        st_q  <= ST_ACTIVE;
                        if (len_i == '0) begin
                            remain_q <= LEN_W'(1);
                            atn_q    <= 1'b1;
                        end else begin
                            remain_q <= len_i;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (req_ok) begin
                        if (!in_msgout) begin
                            atn_q  <= 1'b0;
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else if (remain_q == '0) begin
                            atn_q    <= 1'b1;
                            remain_q <= len_i;
                            idx_q    <= '0;
                        end else begin
                            data_q   <= bytes_i[idx_q];
                            if (remain_q == LEN_W'(1)) atn_q <= 1'b0;
                            remain_q <= remain_q - 1'b1;
                            idx_q    <= idx_q + 1'b1;
                            st_q     <= ST_DRIVE;
                        end
                    end
                end
                ST_DRIVE: st_q <= ST_ACK;
                ST_ACK: begin
                    if (!req_i) st_q <= ST_ACTIVE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign data_o = data_q;
    assign ack_o  = (st_q == ST_ACK);
    assign atn_o  = atn_q;
    assign done_o = done_q;

endmodule

// File: rtl/msgout_tx.sv
module msgout_tx
    import msgout_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_load,
    input  logic [2:0]  cmd_lun,
    input  logic        cmd_disc,
    input  logic        cmd_tag_en,
    input  logic [1:0]  cmd_tag_type,
    input  logic [7:0]  cmd_tag,
    input  logic        one_req,
    input  logic [7:0]  one_byte,
    input  logic        bus_req,
    input  logic [2:0]  bus_phase,
    input  logic        bus_perr,
    output logic [7:0]  bus_data,
    output logic        bus_ack,
    output logic        bus_atn,
    output logic        phase_done,
    output logic        busy_err
);

    cmd_t                         cmd;
    logic [DEPTH-1:0][BYTE_W-1:0] img;
    logic [LEN_W-1:0]             img_len;
    logic [DEPTH-1:0][BYTE_W-1:0] buf_bytes;
    logic [LEN_W-1:0]             buf_len;
    logic                         idle_ok;
    logic                         clear;
    logic                         nop_fill;
    logic                         cmd_take;
    logic                         one_take;

    assign cmd = '{lun: cmd_lun, disc: cmd_disc, tag_en: cmd_tag_en,
                   tag_type: cmd_tag_type, tag: cmd_tag};

    assign cmd_take = cmd_load && idle_ok;
    assign one_take = one_req && idle_ok && !cmd_load && (buf_len == '0);

    msgout_build #(.DEPTH(DEPTH)) u_build (
        .cmd_i     (cmd),
        .img_o     (img),
        .img_len_o (img_len)
    );

    msgout_buf #(.DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (clear),
        .nop_fill_i (nop_fill),
        .load_cmd_i (cmd_take),
        .img_i      (img),
        .img_len_i  (img_len),
        .one_req_i  (one_req),
        .one_ok_i   (idle_ok && !cmd_load),
        .one_byte_i (one_byte),
        .bytes_o    (buf_bytes),
        .len_o      (buf_len),
        .busy_err_o (busy_err)
    );

    msgout_seq #(.DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_i      (bus_req),
        .phase_i    (bus_phase),
        .perr_i     (bus_perr),
        .bytes_i    (buf_bytes),
        .len_i      (buf_len),
        .atn_set_i  (cmd_take || one_take),
        .idle_ok_o  (idle_ok),
        .clear_o    (clear),
        .nop_fill_o (nop_fill),
        .data_o     (bus_data),
        .ack_o      (bus_ack),
        .atn_o      (bus_atn),
        .done_o     (phase_done)
    );

endmodule

// File: rtl/msgout_chk.sv
module msgout_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_req,
    input logic [7:0] bus_data,
    input logic       bus_ack,
    input logic       bus_atn,
    input logic       phase_done
);

    AST_DATA_BEFORE_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $stable(bus_data)); // R9

    AST_ACK_HOLDS_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && bus_req) |=> bus_ack); // R9

    AST_DATA_STABLE_IN_ACK: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && $past(bus_ack)) |-> $stable(bus_data)); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        phase_done |=> !phase_done); // R6

    AST_DONE_ATN_LOW: assert property (@(posedge clk) disable iff (rst)
        phase_done |-> !bus_atn); // R6

    AST_DONE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        phase_done |-> !bus_ack); // R6

endmodule

bind msgout_tx msgout_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_data   (bus_data),
    .bus_ack    (bus_ack),
    .bus_atn    (bus_atn),
    .phase_done (phase_done)
);

// File: tb/msgout_tx_bench.sv
module msgout_tx_bench;

    localparam logic [2:0] PH_MO = 3'b110;
    localparam logic [2:0] PH_MI = 3'b111;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_load = 1'b0;
    logic [2:0] cmd_lun = '0;
    logic       cmd_disc = 1'b0;
    logic       cmd_tag_en = 1'b0;
    logic [1:0] cmd_tag_type = '0;
    logic [7:0] cmd_tag = '0;
    logic       one_req = 1'b0;
    logic [7:0] one_byte = '0;
    logic       bus_req = 1'b0;
    logic [2:0] bus_phase = PH_MO;
    logic       bus_perr = 1'b0;
    logic [7:0] bus_data;
    logic       bus_ack;
    logic       bus_atn;
    logic       phase_done;
    logic       busy_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    msgout_tx u_msgout_tx (
        .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_lun(cmd_lun),
        .cmd_disc(cmd_disc), .cmd_tag_en(cmd_tag_en), .cmd_tag_type(cmd_tag_type),
        .cmd_tag(cmd_tag), .one_req(one_req), .one_byte(one_byte),
        .bus_req(bus_req), .bus_phase(bus_phase), .bus_perr(bus_perr),
        .bus_data(bus_data), .bus_ack(bus_ack), .bus_atn(bus_atn),
        .phase_done(phase_done), .busy_err(busy_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Expected-message model: bytes computed from the requirement encodings
    byte unsigned exp_q[$];

    function automatic byte unsigned ident(input int lun, input bit disc);
        return byte'(8'h80 | (disc ? 8'h40 : 8'h00) | lun);
    endfunction

    // target side: one REQ/ACK handshake, returns byte, ATN at ACK and latency
    task automatic tgt_byte(output byte unsigned d, output bit atn, output int lat);
        bus_phase = PH_MO;
        bus_req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!bus_ack && lat < 50);
        d = bus_data;
        atn = bus_atn;
        bus_req = 1'b0;
        for (int k = 0; k < 50 && bus_ack; k++) @(negedge clk);
    endtask

    task automatic send_expect(input string req, input bit [7:0] exp_d, input bit exp_atn);
        byte unsigned d; bit a; int l;
        tgt_byte(d, a, l);
        chk(d == exp_d, req, d, exp_d);
        chk(a == exp_atn, {req, " atn"}, a, exp_atn);
    endtask

    task automatic tgt_leave(input string req);
        bus_phase = PH_MI;
        bus_req = 1'b1;
        @(negedge clk);
        chk(phase_done == 1'b1, {req, " done"}, phase_done, 1);
        chk(bus_atn == 1'b0 && bus_ack == 1'b0, {req, " atn/ack"}, {bus_atn, bus_ack}, 0);
        bus_req = 1'b0;
        bus_phase = PH_MO;
        @(negedge clk);
        chk(phase_done == 1'b0, {req, " pulse"}, phase_done, 0);
    endtask

    task automatic load_cmd(input int lun, input bit disc, input bit ten,
                            input int ttype, input int tag);
        cmd_lun = 3'(lun); cmd_disc = disc; cmd_tag_en = ten;
        cmd_tag_type = 2'(ttype); cmd_tag = 8'(tag);
        cmd_load = 1'b1;
        @(negedge clk);
        cmd_load = 1'b0;
    endtask

    initial begin
        byte unsigned d; bit a; int lat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({bus_ack, bus_atn, phase_done, busy_err} == 4'b0, "R1", {bus_ack, bus_atn, phase_done, busy_err}, 0);
        chk(bus_data == 8'h00, "R1 data", bus_data, 0);

        // R2 identify only
        load_cmd(5, 1'b1, 1'b0, 0, 0);
        chk(bus_atn == 1'b1, "R2 atn", bus_atn, 1);
        send_expect("R2 R7", ident(5, 1'b1), 1'b0);
        tgt_leave("R6");

        // R4 and R6: buffer was emptied, so a new entry sends a no-op
        send_expect("R4 R6", 8'h08, 1'b0);
        tgt_leave("R4");

        // R3 tagged message, R9 latency mid-message, R8 resend
        exp_q = {};
        exp_q.push_back(ident(2, 1'b0));
        exp_q.push_back(byte'(8'h20 | 1));
        exp_q.push_back(8'h5A);
        load_cmd(2, 1'b0, 1'b1, 1, 8'h5A);
        send_expect("R3 b0 R7", exp_q[0], 1'b1);
        tgt_byte(d, a, lat);
        chk(d == exp_q[1], "R3 b1", d, exp_q[1]);
        chk(lat == 2, "R9 latency", lat, 2);
        send_expect("R3 b2 R7", exp_q[2], 1'b0);
        send_expect("R8 resend b0", exp_q[0], 1'b1);
        send_expect("R8 resend b1", exp_q[1], 1'b1);
        send_expect("R8 resend b2", exp_q[2], 1'b0);
        tgt_leave("R8");

        // R9: ACK held while REQ stays high
        load_cmd(3, 1'b0, 1'b0, 0, 0);
        bus_req = 1'b1;
        for (int k = 0; k < 20 && !bus_ack; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(bus_ack == 1'b1, "R9 hold", bus_ack, 1);
        chk(bus_data == ident(3, 1'b0), "R9 data", bus_data, ident(3, 1'b0));
        bus_req = 1'b0;
        @(negedge clk);
        chk(bus_ack == 1'b0, "R9 release", bus_ack, 0);
        tgt_leave("R9");

        // R5 parity error holds off the handshake
        load_cmd(1, 1'b0, 1'b0, 0, 0);
        bus_perr = 1'b1;
        bus_req = 1'b1;
        repeat (5) @(negedge clk);
        chk(bus_ack == 1'b0, "R5 no ack", bus_ack, 0);
        bus_perr = 1'b0;
        send_expect("R5 after", ident(1, 1'b0), 1'b0);
        tgt_leave("R5");

        // R10 single byte, R11 busy
        one_byte = 8'h07;
        one_req = 1'b1;
        @(negedge clk);
        one_req = 1'b0;
        chk(bus_atn == 1'b1, "R10 atn", bus_atn, 1);
        chk(busy_err == 1'b0, "R10 busy", busy_err, 0);
        one_byte = 8'h0C;
        one_req = 1'b1;
        @(negedge clk);
        one_req = 1'b0;
        chk(busy_err == 1'b1, "R11 busy", busy_err, 1);
        @(negedge clk);
        chk(busy_err == 1'b0, "R11 pulse", busy_err, 0);
        send_expect("R10 R11 byte", 8'h07, 1'b0);
        tgt_leave("R10");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule